// File: doc/BRIEF.md
# DSD to DoP Word Packer

This block turns two native one-bit DSD streams (left and right) into 24-bit DoP sample words. This lets a PCM-width sample-pair path carry DSD content without a separate data path. The serial bit clock and both data bits are brought into the system clock domain through a short synchronizer. Each rising edge of the bit clock shifts one bit into each channel. After sixteen edges the block emits one stereo pair. Each word of the pair holds an 8-bit marker above the sixteen collected bits.

The marker alternates from pair to pair. Both words of a pair always carry the same marker. A disable or a flush drops a partly filled frame and restarts the marker sequence, so that a new stream always begins from a known state. The word rate is the DSD bit rate divided by sixteen. For example, a 11.2896 MHz bit stream yields pairs at 705.6 kHz.

Top module: `dsd_dop_packer`

## Requirements
- R1: While rst_ni is low and after its release until the first completed frame, dop_valid_o is 0 and both output words are 0.
- R2: dop_valid_o pulses high for exactly one clk_i cycle for every sixteen bit clock rising edges accepted while enabled, and at no other time.
- R3: Each output word holds the marker in bits 23:16 and the sixteen channel bits in bits 15:0. The first bit of a frame lands in bit 15 and the last bit lands in bit 0.
- R4: The marker is 0x05 on the first frame after reset, disable or flush. It then alternates between 0xFA and 0x05 on each following frame.
- R5: The left word (from dsd_l_i) and the right word (from dsd_r_i) of one frame appear together in the same valid cycle and carry the same marker.
- R6: While enable_i is 0, bit clock edges are ignored: no pair is produced. A partial frame and the marker phase are discarded, so the next frame after re-enable starts at bit 15 with marker 0x05.
- R7: A one-cycle pulse on flush_i discards the bits of a partial frame and resets the marker phase. The next sixteen bits form a fresh frame with marker 0x05.
- R8: The output words hold their value in every cycle where dop_valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Accept DSD bits when high |
| flush_i | input | 1 | Drop partial frame and restart marker phase |
| dsd_bclk_i | input | 1 | DSD bit clock, data taken on its rising edge |
| dsd_l_i | input | 1 | Left channel DSD bit |
| dsd_r_i | input | 1 | Right channel DSD bit |
| dop_valid_o | output | 1 | One-cycle strobe marking a new word pair |
| dop_l_o | output | 24 | Left DoP word |
| dop_r_o | output | 24 | Right DoP word |

## Verification
The hardest states to reach from the ports are a frame cut off partway through and a marker sequence that restarts from an odd phase. Neither is visible until sixteen further bits have been clocked in. The stimulus therefore stops a frame after a few bits, sometimes after the marker has already moved to 0xFA. It then applies a flush or drops enable, and afterwards toggles the bit clock while disabled. The scoreboard keeps its own bit count and marker phase. It predicts which payload bits and which marker the next pair must show, so any leftover bit or stale phase shows up as a mismatch.

// File: rtl/dop_pkg.sv
package dop_pkg;
  localparam int unsigned PAYLOAD_W = 16;
  localparam int unsigned MARKER_W  = 8;
  localparam logic [MARKER_W-1:0] MARKER_FIRST  = 8'h05;
  localparam logic [MARKER_W-1:0] MARKER_SECOND = 8'hFA;
  localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/dop_edge_sync.sv
module dop_edge_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bclk_i,
  input  logic [W-1:0] bits_i,
  output logic         edge_o,
  output logic [W-1:0] bits_o
);
  logic [STAGES-1:0]        bclk_q;
  logic [STAGES-1:0][W-1:0] bits_q;
  logic                     bclk_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q      <= '0;
      bits_q      <= '0;
      bclk_prev_q <= 1'b0;
    end else begin
      bclk_q[0]   <= bclk_i;
      bits_q[0]   <= bits_i;
      for (int i = 1; i < int'(STAGES); i++) begin
        bclk_q[i] <= bclk_q[i-1];
        bits_q[i] <= bits_q[i-1];
      end
      bclk_prev_q <= bclk_q[STAGES-1];
    end
  end

  // data travels with the clock, so both are aligned at the detected edge
  assign edge_o = bclk_q[STAGES-1] & ~bclk_prev_q;
  assign bits_o = bits_q[STAGES-1];
endmodule

// File: rtl/dop_lane_shift.sv
module dop_lane_shift #(
  parameter int unsigned PAYLOAD_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clear_i,
  input  logic                 shift_i,
  input  logic                 bit_i,
  output logic [PAYLOAD_W-1:0] payload_next_o
);
  logic [PAYLOAD_W-2:0] sh_q;

  assign payload_next_o = {sh_q, bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sh_q <= '0;
    else if (clear_i)  sh_q <= '0;
    else if (shift_i)  sh_q <= payload_next_o[PAYLOAD_W-2:0];
  end
endmodule

// File: rtl/dop_frame_ctrl.sv
module dop_frame_ctrl #(
  parameter int unsigned PAYLOAD_W = 16,
  parameter int unsigned MARKER_W  = 8,
  parameter logic [MARKER_W-1:0] MARKER_FIRST  = 8'h05,
  parameter logic [MARKER_W-1:0] MARKER_SECOND = 8'hFA
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                shift_i,
  output logic                frame_done_o,
  output logic [MARKER_W-1:0] marker_o
);
  localparam int unsigned CNT_W = $clog2(PAYLOAD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PAYLOAD_W - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             phase_q;

  assign frame_done_o = shift_i && (cnt_q == LAST);
  assign marker_o     = phase_q ? MARKER_SECOND : MARKER_FIRST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (shift_i) begin
      cnt_q <= frame_done_o ? '0 : cnt_q + 1'b1;
      if (frame_done_o) phase_q <= ~phase_q;
    end
  end
endmodule

// File: rtl/dsd_dop_packer.sv
module dsd_dop_packer #(
  parameter int unsigned PAYLOAD_W   = dop_pkg::PAYLOAD_W,
  parameter int unsigned MARKER_W    = dop_pkg::MARKER_W,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [MARKER_W-1:0] MARKER_FIRST  = dop_pkg::MARKER_FIRST,
  parameter logic [MARKER_W-1:0] MARKER_SECOND = dop_pkg::MARKER_SECOND
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          enable_i,
  input  logic                          flush_i,
  input  logic                          dsd_bclk_i,
  input  logic                          dsd_l_i,
  input  logic                          dsd_r_i,
  output logic                          dop_valid_o,
  output logic [MARKER_W+PAYLOAD_W-1:0] dop_l_o,
  output logic [MARKER_W+PAYLOAD_W-1:0] dop_r_o
);
  localparam int unsigned NUM_CH = dop_pkg::NUM_CH;
  localparam int unsigned WORD_W = MARKER_W + PAYLOAD_W;

  logic                              bit_edge;
  logic [NUM_CH-1:0]                 bits_sync;
  logic                              clear;
  logic                              shift;
  logic                              frame_done;
  logic [MARKER_W-1:0]               marker;
  logic [NUM_CH-1:0][PAYLOAD_W-1:0]  payload_next;
  logic [NUM_CH-1:0][WORD_W-1:0]     word_q;
  logic                              valid_q;

  assign clear = !enable_i || flush_i;
  assign shift = bit_edge && !clear;

  dop_edge_sync #(.STAGES(SYNC_STAGES), .W(NUM_CH)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bclk_i (dsd_bclk_i),
    .bits_i ({dsd_r_i, dsd_l_i}),
    .edge_o (bit_edge),
    .bits_o (bits_sync)
  );

  dop_frame_ctrl #(
    .PAYLOAD_W     (PAYLOAD_W),
    .MARKER_W      (MARKER_W),
    .MARKER_FIRST  (MARKER_FIRST),
    .MARKER_SECOND (MARKER_SECOND)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (clear),
    .shift_i      (shift),
    .frame_done_o (frame_done),
    .marker_o     (marker)
  );

  for (genvar ch = 0; ch < int'(NUM_CH); ch++) begin : g_lane
    dop_lane_shift #(.PAYLOAD_W(PAYLOAD_W)) u_lane (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .clear_i        (clear),
      .shift_i        (shift),
      .bit_i          (bits_sync[ch]),
      .payload_next_o (payload_next[ch])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         word_q[ch] <= '0;
      else if (frame_done) word_q[ch] <= {marker, payload_next[ch]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= frame_done;
  end

  assign dop_valid_o = valid_q;
  assign dop_l_o     = word_q[0];
  assign dop_r_o     = word_q[1];
endmodule

// File: rtl/dsd_dop_packer_chk.sv
module dsd_dop_packer_chk #(
  parameter int unsigned PAYLOAD_W = 16,
  parameter int unsigned MARKER_W  = 8,
  parameter logic [MARKER_W-1:0] MARKER_FIRST = 8'h05
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          enable_i,
  input logic                          flush_i,
  input logic                          dop_valid_o,
  input logic [MARKER_W+PAYLOAD_W-1:0] dop_l_o,
  input logic [MARKER_W+PAYLOAD_W-1:0] dop_r_o
);
  localparam int unsigned TOP = MARKER_W + PAYLOAD_W - 1;

  logic                seen_q;
  logic [MARKER_W-1:0] last_mark_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q      <= 1'b0;
      last_mark_q <= '0;
    end else if (!enable_i || flush_i) begin
      seen_q      <= 1'b0;
    end else if (dop_valid_o) begin
      seen_q      <= 1'b1;
      last_mark_q <= dop_l_o[TOP -: MARKER_W];
    end
  end

  // R2
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dop_valid_o |=> !dop_valid_o);

  // R5
  marker_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dop_valid_o |-> dop_l_o[TOP -: MARKER_W] == dop_r_o[TOP -: MARKER_W]);

  // R4
  marker_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dop_valid_o && !seen_q) |-> dop_l_o[TOP -: MARKER_W] == MARKER_FIRST);

  // R4
  marker_alt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dop_valid_o && seen_q) |-> dop_l_o[TOP -: MARKER_W] != last_mark_q);

  // R6
  idle_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !dop_valid_o);

  // R8
  hold_words_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dop_valid_o |-> ($stable(dop_l_o) && $stable(dop_r_o)));
endmodule

bind dsd_dop_packer dsd_dop_packer_chk #(
  .PAYLOAD_W    (PAYLOAD_W),
  .MARKER_W     (MARKER_W),
  .MARKER_FIRST (MARKER_FIRST)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .enable_i    (enable_i),
  .flush_i     (flush_i),
  .dop_valid_o (dop_valid_o),
  .dop_l_o     (dop_l_o),
  .dop_r_o     (dop_r_o)
);

// File: tb/dsd_dop_packer_tb_top.sv
`timescale 1ns/1ps
module dsd_dop_packer_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enable_i = 1'b0;
  logic        flush_i = 1'b0;
  logic        dsd_bclk_i = 1'b0;
  logic        dsd_l_i = 1'b0;
  logic        dsd_r_i = 1'b0;
  logic        dop_valid_o;
  logic [23:0] dop_l_o;
  logic [23:0] dop_r_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  dsd_dop_packer dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .flush_i(flush_i),
    .dsd_bclk_i(dsd_bclk_i), .dsd_l_i(dsd_l_i), .dsd_r_i(dsd_r_i),
    .dop_valid_o(dop_valid_o), .dop_l_o(dop_l_o), .dop_r_o(dop_r_o)
  );

  // scoreboard model
  logic [47:0] exp_q[$];
  logic [15:0] m_l, m_r;
  int          m_cnt = 0;
  bit          m_phase = 1'b0;

  task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    m_cnt = 0; m_phase = 1'b0; m_l = '0; m_r = '0;
  endtask

  // R3 R4: bench prediction of word layout and marker
  task automatic send_bit(input bit l, input bit r);
    if (enable_i) begin
      m_l = {m_l[14:0], l};
      m_r = {m_r[14:0], r};
      m_cnt++;
      if (m_cnt == 16) begin
        logic [7:0] mk;
        mk = m_phase ? 8'hFA : 8'h05;
        exp_q.push_back({mk, m_l, mk, m_r});
        m_phase = ~m_phase;
        m_cnt = 0;
      end
    end
    dsd_l_i = l; dsd_r_i = r;
    repeat (2) @(negedge clk_i);
    dsd_bclk_i = 1'b1;
    repeat (4) @(negedge clk_i);
    dsd_bclk_i = 1'b0;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic send_frame(input logic [15:0] l, input logic [15:0] r);
    for (int i = 15; i >= 0; i--) send_bit(l[i], r[i]);
  endtask

  // monitor
  bit          prev_valid = 1'b0;
  logic [23:0] last_l = '0, last_r = '0;
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      if (dop_valid_o) begin
        check(!prev_valid, "R2 pulse width", {47'd0, prev_valid}, 48'd0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected pair", {dop_l_o, dop_r_o}, 48'd0);
        end else begin
          logic [47:0] e;
          e = exp_q.pop_front();
          check(dop_l_o == e[47:24], "R3 R4 left word", {24'd0, dop_l_o}, {24'd0, e[47:24]});
          check(dop_r_o == e[23:0], "R5 right word", {24'd0, dop_r_o}, {24'd0, e[23:0]});
        end
        last_l = dop_l_o; last_r = dop_r_o;
      end else begin
        check(dop_l_o == last_l && dop_r_o == last_r, "R8 hold",
              {dop_l_o, dop_r_o}, {last_l, last_r});
      end
      prev_valid = dop_valid_o;
    end
  end

  task automatic finish_sim();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_sim();
  end

  initial begin
    model_clear();
    repeat (5) @(negedge clk_i);
    // R1
    check(dop_valid_o == 1'b0 && dop_l_o == '0 && dop_r_o == '0, "R1 reset state",
          {dop_l_o, dop_r_o}, 48'd0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check(dop_valid_o == 1'b0 && dop_l_o == '0, "R1 after release", {24'd0, dop_l_o}, 48'd0);
    enable_i = 1'b1;

    // R2 R3 R4 R5: several patterns, marker alternates
    send_frame(16'hFFFF, 16'h0000);
    send_frame(16'h8001, 16'h7FFE);
    send_frame(16'hA55A, 16'h3C96);
    send_frame(16'h1234, 16'hFEDC);

    // R7: flush mid-frame while phase is 0xFA
    send_frame(16'h0F0F, 16'hF0F0);
    for (int i = 0; i < 7; i++) send_bit(1'b1, 1'b0);
    flush_i = 1'b1; @(negedge clk_i); flush_i = 1'b0;
    model_clear();
    send_frame(16'h00FF, 16'hC003);
    send_frame(16'h6A6A, 16'h9191);

    // R6: disable mid-frame, toggle bits while off
    for (int i = 0; i < 9; i++) send_bit(1'b0, 1'b1);
    enable_i = 1'b0;
    model_clear();
    for (int i = 0; i < 20; i++) send_bit(i[0], ~i[0]);
    enable_i = 1'b1;
    for (int f = 0; f < 3; f++) send_frame(16'($urandom), 16'($urandom));

    repeat (10) @(negedge clk_i);
    // R2: every predicted pair was delivered
    check(exp_q.size() == 0, "R2 all pairs seen", 48'(exp_q.size()), 48'd0);
    finish_sim();
  end
endmodule